// File: doc/BRIEF.md
# NAND flash device command interface

A synthesizable behavioural model of the device end of an 8-bit asynchronous NAND flash bus, intended as a target that a host flash controller can be tested against. All bus pins are treated as synchronous to the model clock. The model finds the rising edge of the write strobe and sorts the byte on the bus by the two latch-enable levels into command, address or data. It decodes page read, cache read, random data output, page program with random data input, block erase, status, identifier read and reset.

Busy periods are small clock-cycle counters set by parameters, and the active-low ready/busy pin is low for the whole count. The storage is a tiny page array with one page-wide program buffer, so a host can check real data round trips. The model flags every protocol violation in a sticky error output that the bench checks.

Top module: `nand_dev_if`

## Requirements
- R1: On a rising `we_n` edge the byte on `io_in` is a command when `cle`=1 and `ale`=0, an address when `ale`=1 and `cle`=0, and a data byte when both are 0.
- R2: Read is 00h, five address cycles (column low, column high, three row bytes, with the page taken from the first row byte), then 30h. `rb_n` is then low for exactly T_READ cycles. Each later `re_n` rising edge steps the column, and `io_out` shows the byte at the current column while `re_n` is low.
- R3: Program is 80h, five address cycles, data bytes stored at successive columns, then 10h. `rb_n` is low for exactly T_PROG cycles, after which each byte of the page is the old value ANDed with the buffered byte. Bytes not written count as FFh. 85h followed by two column cycles moves the write column without clearing the buffer.
- R4: Erase is 60h, three row cycles, then D0h. `rb_n` is low for exactly T_ERASE cycles, after which every byte reads FFh.
- R5: 70h selects the status byte on `io_out`: bit 0 is 1 for a failed operation, bit 6 is 1 when ready, bit 7 equals `wp_n`, and the other bits are 0. Status stays selected across any number of reads and busy periods until another command is written.
- R6: 90h followed by one address cycle selects identifier output. Successive reads give ADh, 3Ch, 01h, 2Ah, 44h, and the last byte repeats after that.
- R7: FFh makes `rb_n` low for T_RESET cycles, clears the fail bit and returns the decoder to idle. A FFh written while a reset is counting is ignored, so the busy period is not restarted.
- R8: `wp_n` low while a program or erase is busy ends the busy period on the next clock, leaves the array unchanged and sets the fail bit. `wp_n` low when 10h or D0h is written starts no busy period and sets the fail bit.
- R9: 31h after a completed read moves to the next page at column 0 and makes `rb_n` low for T_READ cycles. 31h on the last page starts no busy period and sets `proto_err`.
- R10: After a completed read, 05h followed by two column cycles and E0h moves the output column to the given column.
- R11: An unknown command, an address or data byte in a state that does not expect it, or a known command in the wrong state sets `proto_err` and returns the decoder to idle. `proto_err` stays set until `rst_n` is asserted.
- R12: After reset `rb_n`=1, `proto_err`=0, `io_out`=FFh, and every array byte is FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| we_n | input | 1 | Write strobe, active low, bus sampled on its rising edge |
| re_n | input | 1 | Read strobe, active low, column steps on its rising edge |
| wp_n | input | 1 | Write protect, active low, used live |
| io_in | input | 8 | Byte from host |
| io_out | output | 8 | Byte to host (status, identifier or array data) |
| rb_n | output | 1 | Ready/busy, low while busy |
| proto_err | output | 1 | Sticky protocol-error flag |

## Verification
A write strobe takes effect on the first clock edge that sees `we_n` high again. The bench therefore keeps `cle`, `ale` and `io_in` stable until the falling clock edge after that, and checks `rb_n` and `proto_err` there. Busy lengths are measured as the number of rising clock edges between the confirm byte taking effect and the first falling edge with `rb_n` high, and must equal the parameter exactly. Read data is combinational from the current column, so the monitor samples `io_out` at the falling edge while `re_n` is still low, before the column step on the `re_n` rise. Abort by write protect is expected one clock after `wp_n` falls.

// File: rtl/nand_dev_pkg.sv
// Shared types and constants for the NAND device model.
// Command codes and status bit positions are decoded by the host, so they are fixed.
package nand_dev_pkg;

    typedef enum logic [3:0] {
        S_IDLE, S_RD_ADDR, S_RD_CONF, S_RD_DATA, S_PG_ADDR, S_PG_DATA,
        S_RIN_ADDR, S_ER_ADDR, S_ER_CONF, S_RO_ADDR, S_RO_CONF, S_ID_ADDR, S_BUSY
    } ctl_state_t;

    typedef enum logic [1:0] {OUT_NONE, OUT_STATUS, OUT_ARRAY, OUT_ID} out_mode_t;

    typedef enum logic [1:0] {OP_READ, OP_PROG, OP_ERASE, OP_RESET} busy_op_t;

    localparam logic [7:0] CMD_READ       = 8'h00;
    localparam logic [7:0] CMD_READ_GO    = 8'h30;
    localparam logic [7:0] CMD_CACHE      = 8'h31;
    localparam logic [7:0] CMD_RND_OUT    = 8'h05;
    localparam logic [7:0] CMD_RND_OUT_GO = 8'hE0;
    localparam logic [7:0] CMD_PROG       = 8'h80;
    localparam logic [7:0] CMD_RND_IN     = 8'h85;
    localparam logic [7:0] CMD_PROG_GO    = 8'h10;
    localparam logic [7:0] CMD_ERASE      = 8'h60;
    localparam logic [7:0] CMD_ERASE_GO   = 8'hD0;
    localparam logic [7:0] CMD_STATUS     = 8'h70;
    localparam logic [7:0] CMD_ID         = 8'h90;
    localparam logic [7:0] CMD_RESET      = 8'hFF;

    // Address cycle counter limits (last index of each phase)
    localparam logic [2:0] ADDR_LAST = 3'd4;
    localparam logic [2:0] ROW_LAST  = 3'd2;
    localparam logic [2:0] COL_LAST  = 3'd1;
    localparam logic [2:0] PAGE_CYC  = 3'd2;

    localparam logic [2:0] ID_LAST = 3'd4;

    // Identifier byte for a given read index (saturates on the last one)
    function automatic logic [7:0] id_byte(input logic [2:0] idx);
        case (idx)
            3'd0:    return 8'hAD;
            3'd1:    return 8'h3C;
            3'd2:    return 8'h01;
            3'd3:    return 8'h2A;
            default: return 8'h44;
        endcase
    endfunction

endpackage

// File: rtl/nand_edge_det.sv
// Rising-edge detector for an active-low strobe that is already synchronous to clk.
// Assumes the strobe idles high; the stored copy resets high so no edge is seen at reset.
module nand_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    output logic rise
);
    logic prev;

    // Keep last cycle's strobe level
    always_ff @(posedge clk) begin : prev_reg
        if (!rst_n) prev <= 1'b1;
        else        prev <= strobe_n;
    end

    assign rise = strobe_n & ~prev;
endmodule

// File: rtl/nand_busy_timer.sv
// Down-counter for busy periods. Load sets the count, clear drops it to zero.
// done pulses in the cycle whose clock edge brings the count from 1 to 0.
module nand_busy_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             clear,
    output logic [CNT_W-1:0] count,
    output logic             busy,
    output logic             done
);
    // Count down the active busy period
    always_ff @(posedge clk) begin : cnt_reg
        if (!rst_n)              count <= '0;
        else if (clear)          count <= '0;
        else if (load)           count <= load_val;
        else if (count != '0)    count <= count - CNT_W'(1);
    end

    assign busy = (count != '0);
    assign done = (count == CNT_W'(1)) && !clear && !load;
endmodule

// File: rtl/nand_page_store.sv
// Tiny page array plus one program buffer. Commit ANDs the buffer into a page,
// erase sets every byte to FFh. Reads are combinational.
module nand_page_store #(
    parameter int PAGE_BYTES = 16,
    parameter int NUM_PAGES  = 4,
    localparam int COL_W = $clog2(PAGE_BYTES),
    localparam int PG_W  = $clog2(NUM_PAGES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             buf_fill,
    input  logic             buf_we,
    input  logic [COL_W-1:0] buf_col,
    input  logic [7:0]       buf_wdata,
    input  logic             commit,
    input  logic [PG_W-1:0]  commit_page,
    input  logic             erase_all,
    input  logic [PG_W-1:0]  rd_page,
    input  logic [COL_W-1:0] rd_col,
    output logic [7:0]       rd_data
);
    logic [7:0] mem  [NUM_PAGES][PAGE_BYTES];
    logic [7:0] pbuf [PAGE_BYTES];

    // Array and buffer updates
    always_ff @(posedge clk) begin : store_seq
        if (!rst_n) begin
            for (int p = 0; p < NUM_PAGES; p++)
                for (int c = 0; c < PAGE_BYTES; c++) mem[p][c] <= 8'hFF;
            for (int c = 0; c < PAGE_BYTES; c++) pbuf[c] <= 8'hFF;
        end else begin
            if (erase_all) begin
                for (int p = 0; p < NUM_PAGES; p++)
                    for (int c = 0; c < PAGE_BYTES; c++) mem[p][c] <= 8'hFF;
            end else if (commit) begin
                for (int c = 0; c < PAGE_BYTES; c++)
                    mem[commit_page][c] <= mem[commit_page][c] & pbuf[c];
            end
            if (buf_fill) begin
                for (int c = 0; c < PAGE_BYTES; c++) pbuf[c] <= 8'hFF;
            end else if (buf_we) begin
                pbuf[buf_col] <= buf_wdata;
            end
        end
    end

    assign rd_data = mem[rd_page][rd_col];
endmodule

// File: rtl/nand_dev_if.sv
// Device side of an 8-bit asynchronous NAND bus, all pins synchronous to clk.
// Decodes command/address/data bytes on the write-strobe rising edge, runs
// busy periods from parameter counts and drives status, identifier or array data.
// Assumes the host holds cle/ale/io_in stable across the write-strobe rise.
module nand_dev_if
    import nand_dev_pkg::*;
#(
    parameter int PAGE_BYTES = 16,
    parameter int NUM_PAGES  = 4,
    parameter int T_READ     = 6,
    parameter int T_PROG     = 10,
    parameter int T_ERASE    = 14,
    parameter int T_RESET    = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cle,
    input  logic       ale,
    input  logic       we_n,
    input  logic       re_n,
    input  logic       wp_n,
    input  logic [7:0] io_in,
    output logic [7:0] io_out,
    output logic       rb_n,
    output logic       proto_err
);
    localparam int COL_W = $clog2(PAGE_BYTES);
    localparam int PG_W  = $clog2(NUM_PAGES);
    localparam int T_M1  = (T_READ > T_PROG) ? T_READ : T_PROG;
    localparam int T_M2  = (T_ERASE > T_RESET) ? T_ERASE : T_RESET;
    localparam int T_MAX = (T_M1 > T_M2) ? T_M1 : T_M2;
    localparam int CNT_W = $clog2(T_MAX + 1);

    ctl_state_t       state, state_n;
    out_mode_t        out_mode, out_n;
    busy_op_t         op, op_n;
    logic [COL_W-1:0] col, col_n;
    logic [PG_W-1:0]  page, page_n;
    logic [2:0]       acnt, acnt_n, id_idx, idx_n;
    logic             fail, fail_n, perr, err_n;
    logic             we_rise, re_rise, is_cmd, is_addr, is_data;
    logic             t_load, busy, t_done, abort, buf_fill, buf_we;
    logic [CNT_W-1:0] t_val, busy_cnt;
    logic [7:0]       rd_data, status;

    nand_edge_det u_we (.clk(clk), .rst_n(rst_n), .strobe_n(we_n), .rise(we_rise));
    nand_edge_det u_re (.clk(clk), .rst_n(rst_n), .strobe_n(re_n), .rise(re_rise));

    nand_busy_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .clear(abort),
        .count(busy_cnt), .busy(busy), .done(t_done));

    nand_page_store #(.PAGE_BYTES(PAGE_BYTES), .NUM_PAGES(NUM_PAGES)) u_store (
        .clk(clk), .rst_n(rst_n), .buf_fill(buf_fill), .buf_we(buf_we), .buf_col(col),
        .buf_wdata(io_in), .commit(t_done && op == OP_PROG), .commit_page(page),
        .erase_all(t_done && op == OP_ERASE), .rd_page(page), .rd_col(col),
        .rd_data(rd_data));

    assign is_cmd  = we_rise & cle & ~ale;
    assign is_addr = we_rise & ale & ~cle;
    assign is_data = we_rise & ~ale & ~cle;
    assign abort   = busy && (op == OP_PROG || op == OP_ERASE) && !wp_n;

    // Next-state decode of bus cycles, busy completion and read strobes
    always_comb begin : decode
        state_n = state; out_n = out_mode; op_n = op; col_n = col; page_n = page;
        acnt_n = acnt; idx_n = id_idx; fail_n = fail; err_n = perr;
        t_load = 1'b0; t_val = '0; buf_fill = 1'b0; buf_we = 1'b0;
        if (abort) begin
            state_n = S_IDLE; fail_n = 1'b1;
        end else if (t_done) begin
            state_n = (op == OP_READ) ? S_RD_DATA : S_IDLE;
        end
        if (is_cmd) begin
            if (io_in == CMD_STATUS) begin
                out_n = OUT_STATUS;
            end else if (io_in == CMD_RESET) begin
                if (!(busy && op == OP_RESET)) begin
                    t_load = 1'b1; t_val = CNT_W'(T_RESET); op_n = OP_RESET;
                    state_n = S_BUSY; out_n = OUT_NONE; fail_n = 1'b0;
                end
            end else if (busy) begin
                err_n = 1'b1;
            end else begin
                out_n = OUT_NONE; state_n = S_IDLE; acnt_n = '0;
                case (io_in)
                    CMD_READ:  state_n = S_RD_ADDR;
                    CMD_PROG:  begin state_n = S_PG_ADDR; buf_fill = 1'b1; end
                    CMD_ERASE: state_n = S_ER_ADDR;
                    CMD_ID:    state_n = S_ID_ADDR;
                    CMD_READ_GO:
                        if (state == S_RD_CONF) begin
                            t_load = 1'b1; t_val = CNT_W'(T_READ); op_n = OP_READ;
                            state_n = S_BUSY; out_n = OUT_ARRAY;
                        end else err_n = 1'b1;
                    CMD_CACHE:
                        if (state == S_RD_DATA && page != PG_W'(NUM_PAGES - 1)) begin
                            page_n = page + PG_W'(1); col_n = '0;
                            t_load = 1'b1; t_val = CNT_W'(T_READ); op_n = OP_READ;
                            state_n = S_BUSY; out_n = OUT_ARRAY;
                        end else err_n = 1'b1;
                    CMD_RND_OUT:
                        if (state == S_RD_DATA) state_n = S_RO_ADDR;
                        else err_n = 1'b1;
                    CMD_RND_OUT_GO:
                        if (state == S_RO_CONF) begin
                            state_n = S_RD_DATA; out_n = OUT_ARRAY;
                        end else err_n = 1'b1;
                    CMD_RND_IN:
                        if (state == S_PG_DATA) state_n = S_RIN_ADDR;
                        else err_n = 1'b1;
                    CMD_PROG_GO, CMD_ERASE_GO:
                        if ((io_in == CMD_PROG_GO && state == S_PG_DATA) ||
                            (io_in == CMD_ERASE_GO && state == S_ER_CONF)) begin
                            if (wp_n) begin
                                t_load = 1'b1; fail_n = 1'b0; state_n = S_BUSY;
                                t_val = (io_in == CMD_PROG_GO) ? CNT_W'(T_PROG) : CNT_W'(T_ERASE);
                                op_n  = (io_in == CMD_PROG_GO) ? OP_PROG : OP_ERASE;
                            end else fail_n = 1'b1;
                        end else err_n = 1'b1;
                    default: err_n = 1'b1;
                endcase
            end
        end else if (is_addr) begin
            if (busy) err_n = 1'b1;
            else begin
                case (state)
                    S_RD_ADDR, S_PG_ADDR: begin
                        if (acnt == '0) col_n = io_in[COL_W-1:0];
                        if (acnt == PAGE_CYC) page_n = io_in[PG_W-1:0];
                        acnt_n = acnt + 3'd1;
                        if (acnt == ADDR_LAST)
                            state_n = (state == S_RD_ADDR) ? S_RD_CONF : S_PG_DATA;
                    end
                    S_ER_ADDR: begin
                        acnt_n = acnt + 3'd1;
                        if (acnt == ROW_LAST) state_n = S_ER_CONF;
                    end
                    S_RO_ADDR, S_RIN_ADDR: begin
                        if (acnt == '0) col_n = io_in[COL_W-1:0];
                        acnt_n = acnt + 3'd1;
                        if (acnt == COL_LAST)
                            state_n = (state == S_RO_ADDR) ? S_RO_CONF : S_PG_DATA;
                    end
                    S_ID_ADDR: begin state_n = S_IDLE; out_n = OUT_ID; idx_n = '0; end
                    default:   begin state_n = S_IDLE; err_n = 1'b1; end
                endcase
            end
        end else if (is_data && !busy && state == S_PG_DATA) begin
            buf_we = 1'b1; col_n = col + COL_W'(1);
        end else if (we_rise) begin
            err_n = 1'b1;
            if (!busy) state_n = S_IDLE;
        end
        if (re_rise) begin
            if (out_mode == OUT_ARRAY && state == S_RD_DATA) col_n = col + COL_W'(1);
            else if (out_mode == OUT_ID && id_idx != ID_LAST) idx_n = id_idx + 3'd1;
        end
    end

    // Control registers
    always_ff @(posedge clk) begin : ctl_regs
        if (!rst_n) begin
            state <= S_IDLE; out_mode <= OUT_NONE; op <= OP_READ; col <= '0; page <= '0;
            acnt <= '0; id_idx <= '0; fail <= 1'b0; perr <= 1'b0;
        end else begin
            state <= state_n; out_mode <= out_n; op <= op_n; col <= col_n; page <= page_n;
            acnt <= acnt_n; id_idx <= idx_n; fail <= fail_n; perr <= err_n;
        end
    end

    assign status = {wp_n, ~busy, 5'b0, fail};

    // Output byte selection
    always_comb begin : out_mux
        case (out_mode)
            OUT_STATUS: io_out = status;
            OUT_ARRAY:  io_out = rd_data;
            OUT_ID:     io_out = id_byte(id_idx);
            default:    io_out = 8'hFF;
        endcase
    end

    assign rb_n      = ~busy;
    assign proto_err = perr;
endmodule

// File: rtl/nand_dev_if_chk.sv
// Property checker for nand_dev_if, attached by bind below.
module nand_dev_if_chk
    import nand_dev_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cle,
    input logic             ale,
    input logic             we_rise,
    input logic             wp_n,
    input logic [7:0]       io_in,
    input logic [7:0]       io_out,
    input logic             rb_n,
    input logic             proto_err,
    input logic             status_sel,
    input busy_op_t         busy_op,
    input logic [CNT_W-1:0] busy_cnt
);
    // R7
    reset_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_rise && cle && !ale && io_in == CMD_RESET) |=> !rb_n);

    // R7
    reset_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_op == OP_RESET && busy_cnt > CNT_W'(1)) |=> busy_cnt == $past(busy_cnt) - CNT_W'(1));

    // R8
    wp_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rb_n && (busy_op == OP_PROG || busy_op == OP_ERASE) && !wp_n &&
         !(we_rise && cle && io_in == CMD_RESET)) |=> rb_n);

    // R5
    status_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_sel |-> (io_out[6] == rb_n && io_out[7] == wp_n));

    // R11
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);
endmodule

bind nand_dev_if nand_dev_if_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cle(cle), .ale(ale), .we_rise(we_rise), .wp_n(wp_n),
    .io_in(io_in), .io_out(io_out), .rb_n(rb_n), .proto_err(proto_err),
    .status_sel(out_mode == nand_dev_pkg::OUT_STATUS), .busy_op(op), .busy_cnt(busy_cnt));

// File: tb/test_nand_dev_if.sv
// Scoreboard bench: read tasks queue expected bytes, a monitor compares them.
module test_nand_dev_if;
    localparam int T_READ = 6, T_PROG = 10, T_ERASE = 14, T_RESET = 5;

    logic clk = 1'b0, rst_n = 1'b0, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1, wp_n = 1'b1;
    logic [7:0] io_in = 8'h00;
    logic [7:0] io_out;
    logic rb_n, proto_err;
    int checks = 0, failures = 0, cyc = 0;
    logic [7:0] exp_q[$];
    string tag_q[$];
    logic [7:0] mon_val = 8'h00, mon_exp;
    logic mon_fire = 1'b0, done = 1'b0;
    string mon_tag;
    int dur, t0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    nand_dev_if #(.PAGE_BYTES(16), .NUM_PAGES(4), .T_READ(T_READ), .T_PROG(T_PROG),
                  .T_ERASE(T_ERASE), .T_RESET(T_RESET)) i_nand_dev_if (
        .clk(clk), .rst_n(rst_n), .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n),
        .wp_n(wp_n), .io_in(io_in), .io_out(io_out), .rb_n(rb_n), .proto_err(proto_err));

    // Monitor: compare each sampled read byte against the queue head
    always @(posedge clk) if (mon_fire) begin
        checks++;
        if (exp_q.size() == 0) begin
            failures++; $display("FAIL monitor: got %02h expected nothing", mon_val);
        end else begin
            mon_exp = exp_q.pop_front(); mon_tag = tag_q.pop_front();
            if (mon_val !== mon_exp) begin
                failures++; $display("FAIL %s: got %02h expected %02h", mon_tag, mon_val, mon_exp);
            end
        end
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin failures++; $display("FAIL %s: got %0d expected %0d", tag, act, exp); end
    endtask

    task automatic wr(input int kind, input logic [7:0] b);
        @(negedge clk); cle = (kind == 0); ale = (kind == 1); io_in = b; we_n = 1'b0;
        @(negedge clk); we_n = 1'b1;
        @(negedge clk); cle = 1'b0; ale = 1'b0;
    endtask

    task automatic rd(input logic [7:0] exp, input string tag);
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk); re_n = 1'b0;
        @(negedge clk); mon_val = io_out; mon_fire = 1'b1; re_n = 1'b1;
        @(negedge clk); mon_fire = 1'b0;
    endtask

    task automatic addr5(input logic [7:0] c, input logic [7:0] p);
        wr(1, c); wr(1, 8'h00); wr(1, p); wr(1, 8'h00); wr(1, 8'h00);
    endtask

    task automatic wait_ready(input int start, output int d);
        for (int g = 0; g < 1000 && !rb_n; g++) @(negedge clk);
        d = cyc - start;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        failures++; $display("FAIL watchdog: got hang expected completion");
        finish_run();
    end

    initial begin
        do_reset();
        // R12 reset state
        chk(rb_n === 1'b1, "R12 rb_n", rb_n, 1);
        chk(proto_err === 1'b0, "R12 proto_err", proto_err, 0);
        chk(io_out === 8'hFF, "R12 io_out", io_out, 255);
        // R5 status, sticky over reads
        wr(0, 8'h70); rd(8'hC0, "R5 status ready"); rd(8'hC0, "R5 status sticky");
        // R6 identifier
        wr(0, 8'h90); wr(1, 8'h00);
        rd(8'hAD, "R6 id0"); rd(8'h3C, "R6 id1"); rd(8'h01, "R6 id2");
        rd(8'h2A, "R6 id3"); rd(8'h44, "R6 id4"); rd(8'h44, "R6 id hold");
        // R1 R3 program page 1 with random data input
        wr(0, 8'h80); addr5(8'd2, 8'd1);
        wr(2, 8'hA5); wr(2, 8'h5A); wr(2, 8'h33);
        wr(0, 8'h85); wr(1, 8'd8); wr(1, 8'h00); wr(2, 8'h77);
        wr(0, 8'h10); t0 = cyc;
        chk(rb_n === 1'b0, "R3 busy start", rb_n, 0);
        wait_ready(t0, dur); chk(dur == T_PROG, "R3 program busy", dur, T_PROG);
        // R2 read back
        wr(0, 8'h00); addr5(8'd0, 8'd1); wr(0, 8'h30); t0 = cyc;
        wait_ready(t0, dur); chk(dur == T_READ, "R2 read busy", dur, T_READ);
        rd(8'hFF, "R2 col0"); rd(8'hFF, "R2 col1"); rd(8'hA5, "R1 R2 col2");
        rd(8'h5A, "R2 col3"); rd(8'h33, "R2 col4");
        // R10 random data output
        wr(0, 8'h05); wr(1, 8'd8); wr(1, 8'h00); wr(0, 8'hE0);
        rd(8'h77, "R10 col8"); rd(8'hFF, "R10 col9");
        // R3 second program ANDs into cells
        wr(0, 8'h80); addr5(8'd2, 8'd1); wr(2, 8'h0F); wr(0, 8'h10); t0 = cyc;
        wait_ready(t0, dur);
        wr(0, 8'h00); addr5(8'd2, 8'd1); wr(0, 8'h30); t0 = cyc; wait_ready(t0, dur);
        rd(8'h05, "R3 and col2"); rd(8'h5A, "R3 untouched col3");
        // R4 erase, with status read during busy (R5)
        wr(0, 8'h60); wr(1, 8'h00); wr(1, 8'h00); wr(1, 8'h00); wr(0, 8'hD0); t0 = cyc;
        wr(0, 8'h70); rd(8'h80, "R5 status busy");
        wait_ready(t0, dur); chk(dur == T_ERASE, "R4 erase busy", dur, T_ERASE);
        rd(8'hC0, "R5 status sticky after busy");
        wr(0, 8'h00); addr5(8'd2, 8'd1); wr(0, 8'h30); t0 = cyc; wait_ready(t0, dur);
        rd(8'hFF, "R4 erased");
        // program page 3 col0 = 3C for later steps
        wr(0, 8'h80); addr5(8'd0, 8'd3); wr(2, 8'h3C); wr(0, 8'h10); t0 = cyc;
        wait_ready(t0, dur);
        // R8 abort during program busy
        wr(0, 8'h80); addr5(8'd0, 8'd2); wr(2, 8'h00); wr(0, 8'h10);
        repeat (3) @(negedge clk);
        wp_n = 1'b0; @(negedge clk);
        chk(rb_n === 1'b1, "R8 abort ends busy", rb_n, 1);
        wr(0, 8'h70); rd(8'h41, "R8 fail status");
        // R8 protected at erase confirm
        wr(0, 8'h60); wr(1, 8'h00); wr(1, 8'h00); wr(1, 8'h00); wr(0, 8'hD0);
        chk(rb_n === 1'b1, "R8 no busy when protected", rb_n, 1);
        wp_n = 1'b1;
        wr(0, 8'h00); addr5(8'd0, 8'd2); wr(0, 8'h30); t0 = cyc; wait_ready(t0, dur);
        rd(8'hFF, "R8 page2 unchanged");
        wr(0, 8'h00); addr5(8'd0, 8'd3); wr(0, 8'h30); t0 = cyc; wait_ready(t0, dur);
        rd(8'h3C, "R8 page3 kept");
        // R7 reset, repeat ignored, fail cleared
        wr(0, 8'hFF); t0 = cyc;
        wr(0, 8'hFF);
        wait_ready(t0, dur); chk(dur == T_RESET, "R7 reset not restarted", dur, T_RESET);
        wr(0, 8'h70); rd(8'hC0, "R7 fail cleared");
        chk(proto_err === 1'b0, "R11 no error so far", proto_err, 0);
        // R9 cache read
        wr(0, 8'h00); addr5(8'd0, 8'd2); wr(0, 8'h30); t0 = cyc; wait_ready(t0, dur);
        rd(8'hFF, "R9 page2 col0");
        wr(0, 8'h31); t0 = cyc;
        wait_ready(t0, dur); chk(dur == T_READ, "R9 cache busy", dur, T_READ);
        rd(8'h3C, "R9 next page col0");
        wr(0, 8'h31);
        chk(rb_n === 1'b1, "R9 last page no busy", rb_n, 1);
        chk(proto_err === 1'b1, "R9 last page flagged", proto_err, 1);
        // R11 error cases
        do_reset();
        chk(proto_err === 1'b0, "R12 error cleared by rst_n", proto_err, 0);
        wr(0, 8'h42);
        chk(proto_err === 1'b1, "R11 unknown command", proto_err, 1);
        wr(0, 8'h70);
        chk(proto_err === 1'b1, "R11 sticky", proto_err, 1);
        do_reset();
        wr(1, 8'h00);
        chk(proto_err === 1'b1, "R11 address in idle", proto_err, 1);
        do_reset();
        wr(2, 8'h12);
        chk(proto_err === 1'b1, "R11 data in idle", proto_err, 1);
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule